// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Fetch Faults

This block runs ahead of the execution side. It asks the bus controller for instruction words before the decoder needs them and holds the returned words in a small in-order queue. Each fetch response carries an error flag. When a fetch fails, no exception is raised at that point. The flag is stored as a one-bit tag next to the word.

A fault is reported only when the decoder tries to consume a tagged word. At that moment the block raises a single-cycle fault output. The tagged word is never shown as valid data.

A flush input empties the queue in one clock. The flush is used for a branch or a context switch. Any tagged words still waiting are dropped without raising a fault. The response to a fetch that was still in flight when the flush came is thrown away.

Top module: `ifq_core`

## Requirements
- R1: Out of reset the queue is empty: `out_valid` and `fault` are 0 and `fetch_req` is 1.
- R2: `fetch_req` is 1 exactly when no fetch is outstanding and fewer than DEPTH words are held. It is a one-cycle pulse: after a request it stays 0 until the response arrives.
- R3: Accepted words leave in arrival order. `out_data` is the oldest word, and `out_valid` is 1 when that word is untagged. Consuming it (`cons_req`=1) removes it.
- R4: A response with `rsp_err`=1 is stored as a tagged word, and `fault` stays 0 when the response arrives.
- R5: A consume on a tagged head drives `fault`=1 in that same cycle with `out_valid`=0, and it removes the entry.
- R6: `flush`=1 empties the queue at the next edge. In the next cycle `out_valid` is 0, and the dropped tagged words never produce `fault`.
- R7: The response to a fetch outstanding at a flush is discarded. This includes a response arriving in the flush cycle itself. `fetch_req` stays 0 until that response is seen.
- R8: A consume while the queue is empty is ignored: `fault` stays 0 and the next accepted word is still presented first.
- R9: A response that arrives while no fetch is outstanding, or while the queue is full, is ignored and stores nothing.
- R10: The queue holds DEPTH words. With DEPTH words held, `fetch_req` is 0, and the content is kept unchanged until a consume or a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | One-cycle request for the next instruction word |
| rsp_valid | input | 1 | Fetch response present |
| rsp_data | input | WORD_W | Fetched instruction word |
| rsp_err | input | 1 | Bus error on this fetch |
| flush | input | 1 | Drop all held words and any in-flight fetch |
| cons_req | input | 1 | Decoder consumes the head entry |
| out_valid | output | 1 | Head entry present and untagged |
| out_data | output | WORD_W | Head instruction word |
| fault | output | 1 | Deferred fetch fault, raised on consuming a tagged entry |

## Verification
The bench builds the block with its defaults, DEPTH=4 and WORD_W=16. With these values four responses fill the queue, so the full boundary is reachable in a few cycles. This covers the dropped request, a stray response ignored while full, and a complete drain in order. Four entries are also enough to mix tagged and untagged words ahead of a flush, and to check that the dropped tags never raise a fault.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_BUSY  = 2'd1,
      FS_STALE = 2'd2
   } fetch_state_e;

   function automatic int ptr_width(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/ifq_fetch_ctl.sv
module ifq_fetch_ctl
   import ifq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic full,
   input  logic flush,
   input  logic rsp_valid,
   output logic fetch_req,
   output logic accept
);

   fetch_state_e state_q, state_d;

   assign fetch_req = (state_q == FS_IDLE) && !full;
   assign accept    = rsp_valid && (state_q == FS_BUSY) && !flush && !full;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FS_IDLE: begin
            if (fetch_req) state_d = flush ? FS_STALE : FS_BUSY;
         end
         FS_BUSY: begin
            if (rsp_valid)  state_d = FS_IDLE;
            else if (flush) state_d = FS_STALE;
         end
         FS_STALE: begin
            if (rsp_valid) state_d = FS_IDLE;
         end
         default: state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FS_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/ifq_ptrs.sv
module ifq_ptrs #(
   parameter int DEPTH = 4,
   localparam int PTR_W = ifq_pkg::ptr_width(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   logic [PTR_W-1:0] wr_nx, rd_nx;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nx = wr_ptr + PTR_W'(1);
         assign rd_nx = rd_ptr + PTR_W'(1);
      end else begin : g_mod
         assign wr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nx;
         if (pop)  rd_ptr <= rd_nx;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

endmodule

// File: rtl/ifq_store.sv
module ifq_store #(
   parameter int DEPTH  = 4,
   parameter int WORD_W = 16,
   localparam int PTR_W = ifq_pkg::ptr_width(DEPTH),
   localparam int ENT_W = WORD_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              wr_tag,
   output logic [WORD_W-1:0] head_word,
   output logic              head_tag
);

   logic [DEPTH-1:0][ENT_W-1:0] slots;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [ENT_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= '0;
            else if (push && (wr_ptr == PTR_W'(i)))
               slot_q <= {wr_tag, wr_word};
         end
         assign slots[i] = slot_q;
      end
   endgenerate

   assign head_word = slots[rd_ptr][WORD_W-1:0];
   assign head_tag  = slots[rd_ptr][WORD_W];

endmodule

// File: rtl/ifq_core.sv
module ifq_core #(
   parameter int DEPTH  = 4,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              fetch_req,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   input  logic              rsp_err,
   input  logic              flush,
   input  logic              cons_req,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              fault
);

   localparam int PTR_W = ifq_pkg::ptr_width(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ifq_core: DEPTH must be at least 2");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("ifq_core: WORD_W must be at least 1");
      end
   endgenerate

   logic             full, empty, accept, pop;
   logic             head_tag;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;

   assign pop       = cons_req && !empty && !flush;
   assign out_valid = !empty && !head_tag;
   assign fault     = pop && head_tag;

   ifq_fetch_ctl u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .full      (full),
      .flush     (flush),
      .rsp_valid (rsp_valid),
      .fetch_req (fetch_req),
      .accept    (accept)
   );

   ifq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (accept),
      .pop    (pop),
      .flush  (flush),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .count  (cnt),
      .full   (full),
      .empty  (empty)
   );

   ifq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .wr_word   (rsp_data),
      .wr_tag    (rsp_err),
      .head_word (out_data),
      .head_tag  (head_tag)
   );

endmodule

// File: rtl/ifq_checker.sv
module ifq_checker #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fetch_req,
   input logic             flush,
   input logic             cons_req,
   input logic             out_valid,
   input logic             fault,
   input logic [CNT_W-1:0] count
);

   // R2
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> !fetch_req);

   // R5
   fault_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !out_valid);

   // R6
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0) && !out_valid && !fault);

   // R8
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> (!fault && !out_valid));

   // R10
   full_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> !fetch_req);

   // R9
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((count == CNT_W'(DEPTH)) && !cons_req && !flush) |=> (count == CNT_W'(DEPTH)));

endmodule

bind ifq_core ifq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_req (fetch_req),
   .flush     (flush),
   .cons_req  (cons_req),
   .out_valid (out_valid),
   .fault     (fault),
   .count     (cnt)
);

// File: tb/sim_ifq_core.sv
`timescale 1ns/1ps
module sim_ifq_core;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fetch_req;
   logic         rsp_valid = 1'b0;
   logic [W-1:0] rsp_data = '0;
   logic         rsp_err = 1'b0;
   logic         flush = 1'b0;
   logic         cons_req = 1'b0;
   logic         out_valid;
   logic [W-1:0] out_data;
   logic         fault;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   ifq_core #(.DEPTH(4), .WORD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .flush(flush), .cons_req(cons_req),
      .out_valid(out_valid), .out_data(out_data), .fault(fault)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic respond(input logic [W-1:0] d, input logic e, input string tag);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = d; rsp_err = e;
      #1 chk({tag, " fault at fetch"}, 32'(fault), 32'(0));
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
   endtask

   task automatic consume(input logic ev, input logic [W-1:0] ed, input logic ef, input string tag);
      @(negedge clk);
      cons_req = 1'b1;
      #1;
      chk({tag, " valid"}, 32'(out_valid), 32'(ev));
      chk({tag, " fault"}, 32'(fault), 32'(ef));
      if (ev) chk({tag, " data"}, 32'(out_data), 32'(ed));
      @(negedge clk);
      cons_req = 1'b0;
   endtask

   task automatic peek(input logic ev, input logic [W-1:0] ed, input string tag);
      #1;
      chk({tag, " head valid"}, 32'(out_valid), 32'(ev));
      if (ev) chk({tag, " head data"}, 32'(out_data), 32'(ed));
   endtask

   task automatic t_reset();
      #1;
      chk("R1 out_valid", 32'(out_valid), 32'(0));
      chk("R1 fault", 32'(fault), 32'(0));
      chk("R1 fetch_req", 32'(fetch_req), 32'(1));
      @(posedge clk); #1;
      chk("R2 req drops after issue", 32'(fetch_req), 32'(0));
   endtask

   task automatic t_order();
      respond(16'h1111, 1'b0, "R3 a");
      chk("R2 req back after response", 32'(fetch_req), 32'(1));
      respond(16'h2222, 1'b0, "R3 b");
      respond(16'h3333, 1'b0, "R3 c");
      consume(1'b1, 16'h1111, 1'b0, "R3 first");
      consume(1'b1, 16'h2222, 1'b0, "R3 second");
      consume(1'b1, 16'h3333, 1'b0, "R3 third");
      peek(1'b0, '0, "R3 drained");
   endtask

   task automatic t_fill();
      for (int i = 0; i < 4; i++) respond(16'hA000 + 16'(i), 1'b0, "R10 fill");
      #1 chk("R10 no req when full", 32'(fetch_req), 32'(0));
      respond(16'hDEAD, 1'b0, "R9 stray");
      for (int i = 0; i < 4; i++) consume(1'b1, 16'hA000 + 16'(i), 1'b0, "R10 drain");
      peek(1'b0, '0, "R9 stray not stored");
   endtask

   task automatic t_fault();
      respond(16'h0101, 1'b0, "R4 w1");
      respond(16'h0202, 1'b1, "R4 w2 err");
      respond(16'h0303, 1'b0, "R4 w3");
      consume(1'b1, 16'h0101, 1'b0, "R4 clean word");
      peek(1'b0, '0, "R5 tagged head hidden");
      consume(1'b0, '0, 1'b1, "R5 tagged consume");
      consume(1'b1, 16'h0303, 1'b0, "R5 after fault");
   endtask

   task automatic t_flush();
      respond(16'h0E0E, 1'b1, "R6 e1 err");
      respond(16'h0F0F, 1'b0, "R6 e2");
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      peek(1'b0, '0, "R6 flushed");
      chk("R7 no req while stale", 32'(fetch_req), 32'(0));
      consume(1'b0, '0, 1'b0, "R6 dropped tag");
      respond(16'h5555, 1'b0, "R7 stale rsp");
      peek(1'b0, '0, "R7 stale dropped");
      chk("R7 req after stale rsp", 32'(fetch_req), 32'(1));
      respond(16'h7777, 1'b0, "R7 fresh");
      consume(1'b1, 16'h7777, 1'b0, "R7 fresh word");
   endtask

   task automatic t_flush_same();
      @(negedge clk);
      flush = 1'b1; rsp_valid = 1'b1; rsp_data = 16'h9999;
      @(negedge clk);
      flush = 1'b0; rsp_valid = 1'b0;
      peek(1'b0, '0, "R7 same-cycle rsp dropped");
      chk("R7 req after same-cycle", 32'(fetch_req), 32'(1));
      respond(16'hBEEF, 1'b0, "R7 next");
      consume(1'b1, 16'hBEEF, 1'b0, "R7 next word");
   endtask

   task automatic t_empty_consume();
      consume(1'b0, '0, 1'b0, "R8 empty consume");
      respond(16'h4242, 1'b0, "R8 after");
      consume(1'b1, 16'h4242, 1'b0, "R8 word intact");
      peek(1'b0, '0, "R8 empty again");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_order();
      t_fill();
      t_fault();
      t_flush();
      t_flush_same();
      t_empty_consume();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule